// File: doc/BRIEF.md
# PCI Interrupt Pin to Shared-Line Mapper

This block decides which of eight shared interrupt lines (index 0 to 7, called lines A to H) each PCI device interrupt pin (INTA to INTD) drives. Device numbers 25 to 31 each have a programmable 16-bit route register. These registers live in a 16-byte configuration window that accepts byte, word and dword accesses in little-endian byte order. Every other device number uses a fixed rotating map onto lines E to H. Device 30 is wired to lines E to H and its register is read-only zero.

A combinational lookup port takes a device number and a pin number and returns the line index. A write updates the lookup at the next clock edge. The cycle after any write, a one-cycle route-changed flag is raised so that downstream logic can rebuild its routing. Reads are combinational. Decoding of the window's base address is done outside the block.

Top module: `pirq_pin_mapper`

## Requirements
- R1: After reset, every programmable route register reads 16'h3210, which maps INTA to line 0, INTB to 1, INTC to 2 and INTD to 3. The device 30 register and window bytes 14 and 15 read zero.
- R2: The register for device s (25 to 31) sits at byte offset 2*(s-25). The field for pin n occupies bits [4n+3:4n]. Bits [4n+2:4n] give the line index (0=A … 7=H). Bit 4n+3 is stored and read back but has no effect on the lookup.
- R3: For a programmable device, `lk_pirq` equals the low 3 bits of the addressed pin field, combinationally from `lk_slot` and `lk_pin`.
- R4: The device 30 register (offsets 10 and 11) always reads zero and ignores writes. The lookup for device 30 pin n returns 4+n.
- R5: Any device number outside 25 to 31 maps pin n to line ((slot + n) mod 4) + 4.
- R6: A write reaches the lookup and the read path in the first cycle after the write edge. `route_chg` is high in exactly each cycle that follows a cycle with `cfg_wr` high, and is low otherwise.
- R7: `cfg_size` selects the access width: 0 is byte, 1 is word, 2 or 3 is dword. Data byte lane k (bits [8k+7:8k]) maps to window offset (offset + k), which is little-endian.
- R8: Only `cfg_addr[3:0]` selects the offset. The upper address bits are ignored.
- R9: An access that runs past offset 15 is truncated. Lanes beyond the end are not written, they do not wrap to offset 0, and they read as zero.
- R10: Window bytes 14 and 15 are unmapped. They read zero and writes to them are ignored.
- R11: `cfg_rdata` reflects the addressed bytes combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the window access |
| cfg_addr | input | 12 | Access byte address; low 4 bits used |
| cfg_size | input | 2 | Access width: 0 byte, 1 word, 2/3 dword |
| cfg_wdata | input | 32 | Write data, lane 0 at the lowest offset |
| cfg_rdata | output | 32 | Read data for the current address and size |
| lk_slot | input | 5 | Device number to look up |
| lk_pin | input | 2 | Interrupt pin, 0=INTA … 3=INTD |
| lk_pirq | output | 3 | Shared line index, 0=A … 7=H |
| route_chg | output | 1 | One-cycle flag after each write |

## Verification
Reads and lookups are combinational, so the bench sets the address or the device/pin pair at a falling edge and samples 1 ns later, in the same cycle. A write is presented for one cycle from a falling edge. Its effect on the lookup, and the `route_chg` pulse, are due after the next rising edge, so they are sampled at the following falling edge. The bench confirms that `route_chg` has returned low one cycle after that. After every write the bench sweeps all 128 device/pin pairs and every offset at all three access widths, and compares them with a byte-array model.

// File: rtl/pirq_map_pkg.sv
package pirq_map_pkg;
  localparam int BUS_BYTES = 4;
  localparam int REG_BITS  = 16;
  localparam int FIELD_W   = 4;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_DW_ALT = 2'd3
  } acc_size_e;

  function automatic logic [2:0] acc_len(input logic [1:0] sz);
    case (sz)
      ACC_BYTE: acc_len = 3'd1;
      ACC_WORD: acc_len = 3'd2;
      default:  acc_len = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pirq_cfg_access.sv
module pirq_cfg_access
  import pirq_map_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int ADDR_W    = 12
) (
  input  logic                   acc_wr,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [1:0]             acc_size,
  input  logic [BUS_BYTES*8-1:0] acc_wdata,
  input  logic [WIN_BYTES*8-1:0] win_view,
  output logic [WIN_BYTES-1:0]   byte_we,
  output logic [WIN_BYTES*8-1:0] byte_wd,
  output logic [BUS_BYTES*8-1:0] acc_rdata
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int POS_W = OFF_W + 1;

  logic [OFF_W-1:0] base_off;
  logic [2:0]       lanes;
  logic [POS_W-1:0] lane_pos [BUS_BYTES];
  logic             lane_on  [BUS_BYTES];
  logic [ADDR_W-OFF_W-1:0] unused_hi_addr;

  assign base_off       = acc_addr[OFF_W-1:0];
  assign unused_hi_addr = acc_addr[ADDR_W-1:OFF_W];
  assign lanes          = acc_len(acc_size);

  always_comb begin
    for (int k = 0; k < BUS_BYTES; k++) begin
      lane_pos[k] = {1'b0, base_off} + POS_W'(k);
      lane_on[k]  = (3'(k) < lanes) && (lane_pos[k] < POS_W'(WIN_BYTES));
    end
  end

  always_comb begin
    byte_we   = '0;
    byte_wd   = '0;
    acc_rdata = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (lane_on[k]) begin
        acc_rdata[8*k +: 8] = win_view[int'(lane_pos[k][OFF_W-1:0])*8 +: 8];
        if (acc_wr) begin
          byte_we[lane_pos[k][OFF_W-1:0]] = 1'b1;
          byte_wd[int'(lane_pos[k][OFF_W-1:0])*8 +: 8] = acc_wdata[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_map_pkg::*;
#(
  parameter int             WIN_BYTES = 16,
  parameter int             NUM_REG   = 7,
  parameter int             FIXED_IDX = 5,
  parameter logic [15:0]    RST_VAL   = 16'h3210
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WIN_BYTES-1:0]          byte_we,
  input  logic [WIN_BYTES*8-1:0]        byte_wd,
  output logic [WIN_BYTES*8-1:0]        win_view,
  output logic [NUM_REG*REG_BITS-1:0]   route_flat
);
  localparam int MAPPED = NUM_REG * 2;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    if (r == FIXED_IDX) begin : g_fixed
      assign win_view[r*16 +: 16] = '0;
    end else begin : g_prog
      logic [15:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= RST_VAL;
        end else begin
          for (int j = 0; j < 2; j++) begin
            if (byte_we[2*r + j]) q[8*j +: 8] <= byte_wd[(2*r + j)*8 +: 8];
          end
        end
      end
      assign win_view[r*16 +: 16] = q;
    end
  end

  if (WIN_BYTES > MAPPED) begin : g_gap
    assign win_view[WIN_BYTES*8-1 : MAPPED*8] = '0;
  end

  assign route_flat = win_view[NUM_REG*16-1:0];

  logic unused_ok;
  assign unused_ok = ^{byte_we, byte_wd};
endmodule

// File: rtl/pirq_lookup.sv
module pirq_lookup
  import pirq_map_pkg::*;
#(
  parameter int FIRST_SLOT = 25,
  parameter int NUM_REG    = 7,
  parameter int FIXED_SLOT = 30
) (
  input  logic [NUM_REG*REG_BITS-1:0] route_flat,
  input  logic [4:0]                  slot,
  input  logic [1:0]                  pin,
  output logic [2:0]                  pirq
);
  localparam logic [4:0] LO  = 5'(FIRST_SLOT);
  localparam logic [4:0] HI  = 5'(FIRST_SLOT + NUM_REG - 1);
  localparam logic [4:0] FIX = 5'(FIXED_SLOT);

  logic [4:0] rel;
  logic [1:0] rot;
  assign rel = slot - LO;
  assign rot = slot[1:0] + pin;

  always_comb begin
    if (slot >= LO && slot <= HI) begin
      if (slot == FIX) pirq = {1'b1, pin};
      else pirq = route_flat[int'(rel)*REG_BITS + int'(pin)*FIELD_W +: 3];
    end else begin
      pirq = {1'b1, rot};
    end
  end
endmodule

// File: rtl/pirq_pin_mapper.sv
module pirq_pin_mapper
  import pirq_map_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WIN_BYTES  = 16,
  parameter int FIRST_SLOT = 25,
  parameter int NUM_REG    = 7,
  parameter int FIXED_SLOT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [4:0]        lk_slot,
  input  logic [1:0]        lk_pin,
  output logic [2:0]        lk_pirq,
  output logic              route_chg
);
  localparam int FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

  logic [WIN_BYTES-1:0]        byte_we;
  logic [WIN_BYTES*8-1:0]      byte_wd;
  logic [WIN_BYTES*8-1:0]      win_view;
  logic [NUM_REG*REG_BITS-1:0] route_flat;

  pirq_cfg_access #(.WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W)) u_acc (
    .acc_wr(cfg_wr), .acc_addr(cfg_addr), .acc_size(cfg_size),
    .acc_wdata(cfg_wdata), .win_view(win_view),
    .byte_we(byte_we), .byte_wd(byte_wd), .acc_rdata(cfg_rdata)
  );

  pirq_route_regs #(.WIN_BYTES(WIN_BYTES), .NUM_REG(NUM_REG),
                    .FIXED_IDX(FIXED_IDX), .RST_VAL(16'h3210)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_wd(byte_wd),
    .win_view(win_view), .route_flat(route_flat)
  );

  pirq_lookup #(.FIRST_SLOT(FIRST_SLOT), .NUM_REG(NUM_REG),
                .FIXED_SLOT(FIXED_SLOT)) u_lk (
    .route_flat(route_flat), .slot(lk_slot), .pin(lk_pin), .pirq(lk_pirq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_chg <= 1'b0;
    else        route_chg <= cfg_wr;
  end
endmodule

// File: rtl/pirq_pin_mapper_chk.sv
module pirq_pin_mapper_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [1:0]        cfg_size,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic [4:0]        lk_slot,
  input logic [1:0]        lk_pin,
  input logic [2:0]        lk_pirq,
  input logic              route_chg
);
  // R6
  chg_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> route_chg);
  // R6
  chg_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_chg |-> $past(cfg_wr));
  // R3
  write_reaches_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[3:0] == 4'd0 && cfg_size == 2'd0)
    |=> ((lk_slot == 5'd25 && lk_pin == 2'd0) -> lk_pirq == $past(cfg_wdata[2:0])));
  // R4
  fixed_slot_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot == 5'd30) |-> (lk_pirq == {1'b1, lk_pin}));
  // R4
  fixed_slot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[3:0] == 4'd10 && cfg_size == 2'd1) |-> (cfg_rdata == 32'd0));
  // R5
  default_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot < 5'd25) |-> lk_pirq[2]);
  // R10
  gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[3:0] == 4'd14) |-> (cfg_rdata == 32'd0));
endmodule

bind pirq_pin_mapper pirq_pin_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq), .route_chg(route_chg)
);

// File: tb/tb_pirq_pin_mapper.sv
module tb_pirq_pin_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [1:0]  cfg_size = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;
  logic        route_chg;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [16];

  always #4 clk = ~clk;

  pirq_pin_mapper dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sz_len(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(input int addr, input int sz);
    logic [31:0] v = '0;
    for (int k = 0; k < sz_len(sz); k++) begin
      int pos = (addr & 15) + k;
      if (pos < 16) v[8*k +: 8] = mdl[pos];
    end
    return v;
  endfunction

  function automatic logic [2:0] exp_pirq(input int s, input int p);
    if (s >= 25 && s <= 31) begin
      if (s == 30) return 3'(4 + p);
      return 3'((mdl[2*(s-25) + p/2] >> (4*(p%2))) & 7);
    end
    return 3'(((s + p) % 4) + 4);
  endfunction

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) begin
      for (int sz = 0; sz < 3; sz++) begin
        cfg_addr = 12'(a); cfg_size = 2'(sz);
        #1 chk({tag, " R11 read"}, cfg_rdata, exp_read(a, sz));
      end
    end
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        lk_slot = 5'(s); lk_pin = 2'(p);
        #1 chk({tag, (s == 30) ? " R4 lookup" : (s >= 25) ? " R3 lookup" : " R5 lookup"},
               32'(lk_pirq), 32'(exp_pirq(s, p)));
      end
    end
  endtask

  task automatic model_wr(input int addr, input int sz, input logic [31:0] d);
    for (int k = 0; k < sz_len(sz); k++) begin
      int pos = (addr & 15) + k;
      if (pos < 16 && pos != 10 && pos != 11 && pos < 14) mdl[pos] = d[8*k +: 8];
    end
  endtask

  task automatic do_wr(input string tag, input int addr, input int sz,
                       input logic [31:0] d, input int s, input int p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 12'(addr); cfg_size = 2'(sz); cfg_wdata = d;
    lk_slot = 5'(s); lk_pin = 2'(p);
    model_wr(addr, sz, d);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    chk({tag, " R6 route_chg high"}, 32'(route_chg), 32'd1);
    chk({tag, " R6 lookup updated"}, 32'(lk_pirq), 32'(exp_pirq(s, p)));
    @(negedge clk);
    #1 chk({tag, " R6 route_chg low"}, 32'(route_chg), 32'd0);
    sweep(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    for (int r = 0; r < 7; r++) if (r != 5) begin mdl[2*r] = 8'h10; mdl[2*r+1] = 8'h32; end
    repeat (3) @(negedge clk);
    #1 chk("R1 route_chg reset", 32'(route_chg), 32'd0);
    rst_n = 1'b1;
    sweep("R1 reset");
    cfg_addr = 12'd0; cfg_size = 2'd1;
    #1 chk("R1 R2 default value", cfg_rdata, 32'h0000_3210);
    do_wr("R2 R7 byte", 0, 0, 32'h0000_0076, 25, 1);
    do_wr("R8 R7 word hi-addr", 12'h102, 1, 32'h0000_4567, 26, 3);
    do_wr("R7 dword", 4, 2, 32'h0123_4567, 28, 2);
    do_wr("R7 dword alt code", 6, 3, 32'h7654_3210, 29, 0);
    do_wr("R4 fixed ignore", 10, 1, 32'h0000_FFFF, 30, 1);
    do_wr("R9 R10 truncate", 12, 2, 32'hEEEE_5432, 31, 2);
    do_wr("R9 no wrap", 13, 2, 32'hAABB_CC55, 31, 3);
    do_wr("R10 gap", 15, 2, 32'h1111_1111, 25, 0);
    do_wr("R2 bit3 ignored", 2, 0, 32'h0000_00F8, 26, 0);
    cfg_addr = 12'd13; cfg_size = 2'd2;
    #1 chk("R9 truncated read", cfg_rdata, 32'h0000_0055);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 12'd0; cfg_size = 2'd0; cfg_wdata = 32'h21;
    model_wr(0, 0, 32'h21);
    @(negedge clk);
    cfg_addr = 12'd1; cfg_wdata = 32'h43;
    model_wr(1, 0, 32'h43);
    #1 chk("R6 back-to-back first", 32'(route_chg), 32'd1);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1 chk("R6 back-to-back second", 32'(route_chg), 32'd1);
    @(negedge clk);
    #1 chk("R6 back-to-back end", 32'(route_chg), 32'd0);
    sweep("R6 back-to-back");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule